// File: doc/BRIEF.md
# Programmable Gain and Mixer Stage with Watch Taps

This block is one link in a digital sensor conditioning chain. Each valid signed sample that arrives is multiplied by a signed fractional coefficient. The product is rounded, saturated back to the sample width and presented one cycle later with its own valid strobe. The coefficient comes from one of two places. The first is a register that software writes: a fixed value gives a constant gain or attenuation, and rewriting it between samples gives a software function generator. The second is an internal numerically controlled oscillator, which makes the stage a mixer for modulation or demodulation.

The oscillator is a phase accumulator. It steps once per input sample and drives a quarter-wave sine table. A first-order phase detector multiplies one selected reference channel by the oscillator's quadrature output. The result is scaled by a loop gain shift and added to the base frequency word, so the oscillator can lock onto the reference channel.

A small register port serves several purposes. Software uses it to configure the stage and to read the latest input and output samples as watchpoints. When the stage is disabled, the output can either pass the input straight through or carry samples that software writes. Two interrupt lines tell software that a new input or output sample is waiting. Each line is cleared by reading the matching capture register, so software can take over a neighbouring step of the chain one sample at a time.

Top module: `gain_mix_stage`

## Requirements
- R1: After reset, out_valid, irq_in, irq_out and reg_rdata are 0, and reading the control register at address 0 returns 0.
- R2: When the control register bit 0 (enable) is 1 and bit 1 is 0, an input sample accepted on in_valid appears on out_data one cycle later with out_valid high. Its value is in_data times the 16-bit Q1.15 register at address 1.
- R3: The product is rounded by adding one half LSB and shifting right arithmetically, which rounds ties toward plus infinity. It then saturates to [-2048, 2047]. A saturated sample sets a sticky flag, which reads back at bit 8 of address 0 and is cleared by a write to address 0 with bit 15 set.
- R4: A coefficient written between two samples applies to the very next sample, so the output follows a waveform rewritten sample by sample.
- R5: With control bit 1 set, the coefficient is the oscillator sine. The oscillator phase is 24 bits and advances by the frequency word on each in_valid, after the current sample has used the phase. The frequency word is {address 4 [7:0], address 3 [15:0]}. Phase quadrants 0, 1, 2 and 3 at table index 0 give 0, +32767, 0 and -32767. Writing address 4 resets the phase to 0.
- R6: When the loop is enabled (address 5 bit 4), a ref_valid pulse stores the phase error. The error is the selected channel times the quadrature output at the current phase, shifted right by 15. The selected channel is address 5 bits [5 +: log2 NREF], and channel i sits in ref_data[i*12 +: 12]. The error, shifted left by address 5 bits [3:0], is added to the frequency word. Unselected channels have no effect.
- R7: When enable is 0 and control bit 2 is 0, each accepted input is passed unchanged to out_data one cycle later with out_valid.
- R8: When enable is 0 and control bit 2 is 1, input samples produce no output. Each write to address 2 instead emits its low 12 bits on out_data one cycle later with out_valid.
- R9: Every accepted input is captured and sets irq_in. A read of address 6 returns the captured input sign-extended, one cycle after reg_rd, and clears irq_in.
- R10: Every output sample sets irq_out. A read of address 7 returns the output node sign-extended and clears irq_out. A new output in the same cycle as the read leaves irq_out set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed input sample |
| ref_valid | input | 1 | Reference sample strobe for the phase detector |
| ref_data | input | NREF*12 | Packed signed reference channels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 12 | Signed output sample |
| irq_in | output | 1 | New input sample waiting |
| irq_out | output | 1 | New output sample waiting |

## Verification
The multiplier is driven from a table of sample and coefficient pairs. Some pairs land exactly on a half LSB, for both signs, which separates tie rounding toward plus infinity from truncation or symmetric rounding. Full-scale pairs, including the one pair of extremes that overflows, separate saturation from wraparound. Rewriting the coefficient between samples shows that the new value applies with no extra delay. A quarter-turn frequency word walks the oscillator through all four quadrants and exposes sign or mirror errors in the table lookup. A reference pulse placed first on the unselected channel and then on the selected one shows that the loop follows only the selected channel. Bypass, software-source and interrupt-clear sequences, including a read that coincides with a new output, cover the handoff to software.

// File: rtl/gms_pkg.sv
package gms_pkg;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_COEF = 3'd1,
        RA_SRC  = 3'd2,
        RA_FLO  = 3'd3,
        RA_FHI  = 3'd4,
        RA_LOOP = 3'd5,
        RA_ITAP = 3'd6,
        RA_OTAP = 3'd7
    } gms_reg_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_OSC_BIT   = 1;
    localparam int CTRL_SRC_BIT   = 2;
    localparam int CTRL_SATCLR    = 15;
    localparam int STAT_SAT_BIT   = 8;
    localparam int STAT_IRQI_BIT  = 9;
    localparam int STAT_IRQO_BIT  = 10;
    localparam int LOOP_EN_BIT    = 4;
    localparam int LOOP_SEL_LSB   = 5;

endpackage

// File: rtl/gms_wave.sv
module gms_wave #(
    parameter int AW = 6,
    parameter int VW = 16
) (
    input  logic [AW+1:0]         ang,
    output logic signed [VW-1:0]  val
);
    localparam int DEPTH = 2 ** AW;
    localparam logic signed [VW-1:0] PEAK = VW'((longint'(1) <<< (VW - 1)) - 1);

    // Rational sine approximation over a half turn of 2*DEPTH steps
    function automatic logic signed [VW-1:0] qsin(input int i);
        longint x, n, num, den;
        x   = longint'(i);
        n   = longint'(2 * DEPTH);
        num = longint'(PEAK) * 16 * x * (n - x);
        den = 5 * n * n - 4 * x * (n - x);
        return VW'(num / den);
    endfunction

    logic signed [VW-1:0] tbl [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
        assign tbl[gi] = qsin(gi);
    end

    logic [1:0]           quad;
    logic [AW-1:0]        idx;
    logic [AW-1:0]        mir;
    logic signed [VW-1:0] mag;

    always_comb begin
        quad = ang[AW+1:AW];
        idx  = ang[AW-1:0];
        mir  = -idx;
        if (quad[0]) begin
            mag = (idx == '0) ? PEAK : tbl[mir];
        end else begin
            mag = tbl[idx];
        end
        val = quad[1] ? -mag : mag;
    end

endmodule

// File: rtl/gms_mult.sv
module gms_mult #(
    parameter int DW = 12,
    parameter int CW = 16
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [CW-1:0] c,
    output logic signed [DW-1:0] y,
    output logic                 sat
);
    localparam int PW2 = DW + CW;
    localparam logic signed [PW2:0]  HALF = (PW2+1)'(longint'(1) <<< (CW - 2));
    localparam logic signed [DW+1:0] MAXV = (DW+2)'((longint'(1) <<< (DW - 1)) - 1);
    localparam logic signed [DW+1:0] MINV = (DW+2)'(-(longint'(1) <<< (DW - 1)));

    logic signed [PW2-1:0] ae, ce, p;
    logic signed [PW2:0]   pr;
    logic signed [DW+1:0]  sh;

    always_comb begin
        ae  = PW2'(a);
        ce  = PW2'(c);
        p   = ae * ce;
        pr  = (PW2+1)'(p) + HALF;
        sh  = pr[PW2:CW-1];
        sat = 1'b0;
        if (sh > MAXV) begin
            y   = MAXV[DW-1:0];
            sat = 1'b1;
        end else if (sh < MINV) begin
            y   = MINV[DW-1:0];
            sat = 1'b1;
        end else begin
            y = sh[DW-1:0];
        end
    end

endmodule

// File: rtl/gms_nco.sv
module gms_nco #(
    parameter int PW = 24,
    parameter int DW = 12,
    parameter int AW = 6,
    parameter int VW = 16,
    parameter int GW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [PW-1:0]        base,
    input  logic                 loop_en,
    input  logic [GW-1:0]        gain,
    input  logic                 ref_valid,
    input  logic signed [DW-1:0] ref_s,
    output logic signed [VW-1:0] sin_o
);
    localparam int ANW = AW + 2;
    localparam int MW  = DW + VW;

    typedef struct packed {
        logic [PW-1:0]        phase;
        logic signed [DW-1:0] pd;
    } nco_st_t;

    nco_st_t st_d, st_q;

    logic [ANW-1:0]        ang_s, ang_c;
    logic signed [VW-1:0]  cos_v;
    logic signed [MW-1:0]  mix;
    logic signed [PW-1:0]  corr;
    logic [PW-1:0]         fw;

    assign ang_s = st_q.phase[PW-1 -: ANW];
    assign ang_c = ang_s + ANW'(1 << AW);

    gms_wave #(.AW(AW), .VW(VW)) u_sin (.ang(ang_s), .val(sin_o));
    gms_wave #(.AW(AW), .VW(VW)) u_cos (.ang(ang_c), .val(cos_v));

    always_comb begin
        st_d = st_q;
        mix  = MW'(ref_s) * MW'(cos_v);
        corr = PW'(st_q.pd) <<< gain;
        fw   = base + (loop_en ? PW'(corr) : '0);
        if (ref_valid) begin
            st_d.pd = mix[MW-2:VW-1];
        end
        if (step) begin
            st_d.phase = st_q.phase + fw;
        end
        if (load) begin
            st_d.phase = '0;
            st_d.pd    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_load_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.phase == '0));

endmodule

// File: rtl/gain_mix_stage.sv
module gain_mix_stage
    import gms_pkg::*;
#(
    parameter int DW   = 12,
    parameter int CW   = 16,
    parameter int PW   = 24,
    parameter int RW   = 16,
    parameter int AW   = 6,
    parameter int GW   = 4,
    parameter int NREF = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    input  logic                 ref_valid,
    input  logic [NREF*DW-1:0]   ref_data,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [2:0]           reg_addr,
    input  logic [RW-1:0]        reg_wdata,
    output logic [RW-1:0]        reg_rdata,
    output logic                 out_valid,
    output logic [DW-1:0]        out_data,
    output logic                 irq_in,
    output logic                 irq_out
);
    localparam int RSW = (NREF > 1) ? $clog2(NREF) : 1;
    localparam int FHW = PW - RW;

    typedef struct packed {
        logic            en;
        logic            osc;
        logic            src;
        logic [CW-1:0]   coef;
        logic [RW-1:0]   flo;
        logic [FHW-1:0]  fhi;
        logic            loop_en;
        logic [GW-1:0]   gain;
        logic [RSW-1:0]  rsel;
        logic [DW-1:0]   in_tap;
        logic [DW-1:0]   out_d;
        logic            out_v;
        logic            irq_i;
        logic            irq_o;
        logic            sat;
        logic [RW-1:0]   rdata;
    } st_t;

    st_t st_d, st_q;

    gms_reg_e              ra;
    logic                  wr_src, load_f;
    logic signed [DW-1:0]  ref_sel;
    logic signed [CW-1:0]  osc_v;
    logic signed [CW-1:0]  coef_use;
    logic signed [DW-1:0]  prod_y;
    logic                  prod_sat;
    logic [RW-1:0]         rd_v;

    assign ra      = gms_reg_e'(reg_addr);
    assign wr_src  = reg_wr && (ra == RA_SRC);
    assign load_f  = reg_wr && (ra == RA_FHI);
    assign ref_sel = ref_data[st_q.rsel*DW +: DW];
    assign coef_use = st_q.osc ? osc_v : st_q.coef;

    gms_nco #(.PW(PW), .DW(DW), .AW(AW), .VW(CW), .GW(GW)) u_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_f),
        .step      (in_valid),
        .base      ({st_q.fhi, st_q.flo}),
        .loop_en   (st_q.loop_en),
        .gain      (st_q.gain),
        .ref_valid (ref_valid),
        .ref_s     (ref_sel),
        .sin_o     (osc_v)
    );

    gms_mult #(.DW(DW), .CW(CW)) u_mult (
        .a   (in_data),
        .c   (coef_use),
        .y   (prod_y),
        .sat (prod_sat)
    );

    always_comb begin
        st_d       = st_q;
        st_d.out_v = 1'b0;
        rd_v       = '0;

        // register reads: data returned next cycle, tap reads clear flags
        if (reg_rd) begin
            unique case (ra)
                RA_CTRL: begin
                    rd_v[CTRL_EN_BIT]   = st_q.en;
                    rd_v[CTRL_OSC_BIT]  = st_q.osc;
                    rd_v[CTRL_SRC_BIT]  = st_q.src;
                    rd_v[STAT_SAT_BIT]  = st_q.sat;
                    rd_v[STAT_IRQI_BIT] = st_q.irq_i;
                    rd_v[STAT_IRQO_BIT] = st_q.irq_o;
                end
                RA_COEF: rd_v = RW'(st_q.coef);
                RA_SRC:  rd_v = '0;
                RA_FLO:  rd_v = st_q.flo;
                RA_FHI:  rd_v = RW'(st_q.fhi);
                RA_LOOP: begin
                    rd_v[GW-1:0]               = st_q.gain;
                    rd_v[LOOP_EN_BIT]          = st_q.loop_en;
                    rd_v[LOOP_SEL_LSB +: RSW]  = st_q.rsel;
                end
                RA_ITAP: begin
                    rd_v       = RW'($signed(st_q.in_tap));
                    st_d.irq_i = 1'b0;
                end
                RA_OTAP: begin
                    rd_v       = RW'($signed(st_q.out_d));
                    st_d.irq_o = 1'b0;
                end
                default: rd_v = '0;
            endcase
            st_d.rdata = rd_v;
        end

        // register writes
        if (reg_wr) begin
            unique case (ra)
                RA_CTRL: begin
                    st_d.en  = reg_wdata[CTRL_EN_BIT];
                    st_d.osc = reg_wdata[CTRL_OSC_BIT];
                    st_d.src = reg_wdata[CTRL_SRC_BIT];
                    if (reg_wdata[CTRL_SATCLR]) begin
                        st_d.sat = 1'b0;
                    end
                end
                RA_COEF: st_d.coef = reg_wdata[CW-1:0];
                RA_FLO:  st_d.flo  = reg_wdata;
                RA_FHI:  st_d.fhi  = reg_wdata[FHW-1:0];
                RA_LOOP: begin
                    st_d.gain    = reg_wdata[GW-1:0];
                    st_d.loop_en = reg_wdata[LOOP_EN_BIT];
                    st_d.rsel    = reg_wdata[LOOP_SEL_LSB +: RSW];
                end
                default: ;
            endcase
        end

        // input node capture
        if (in_valid) begin
            st_d.in_tap = in_data;
            st_d.irq_i  = 1'b1;
        end

        // output node selection
        if (st_q.en) begin
            if (in_valid) begin
                st_d.out_d = prod_y;
                st_d.out_v = 1'b1;
                if (prod_sat) begin
                    st_d.sat = 1'b1;
                end
            end
        end else if (!st_q.src) begin
            if (in_valid) begin
                st_d.out_d = in_data;
                st_d.out_v = 1'b1;
            end
        end else if (wr_src) begin
            st_d.out_d = reg_wdata[DW-1:0];
            st_d.out_v = 1'b1;
        end

        if (st_d.out_v) begin
            st_d.irq_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign out_valid = st_q.out_v;
    assign out_data  = st_q.out_d;
    assign irq_in    = st_q.irq_i;
    assign irq_out   = st_q.irq_o;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.en) |=> out_valid);

    p_sat_extreme_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.en && prod_sat) |=>
            (out_data == {1'b0, {(DW-1){1'b1}}} || out_data == {1'b1, {(DW-1){1'b0}}}));

    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !st_q.en && !st_q.src) |=> (out_valid && out_data == $past(in_data)));

    p_src_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && st_q.src && !wr_src) |=> !out_valid);

    p_itap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> irq_in);

    p_out_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> irq_out);

endmodule

// File: tb/gain_mix_stage_tb.sv
`timescale 1ns/1ps
module gain_mix_stage_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [11:0] in_data;
    logic        ref_valid;
    logic [23:0] ref_data;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        out_valid;
    logic [11:0] out_data;
    logic        irq_in, irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gain_mix_stage u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data),
        .ref_valid(ref_valid), .ref_data(ref_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_data(out_data),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    localparam int NV = 9;
    localparam logic signed [11:0] T_IN [NV] = '{
        12'sd1000, -12'sd1000, 12'sd3, -12'sd3, 12'sd2047,
        -12'sd2048, -12'sd2048, 12'sd2047, 12'sd100 };
    localparam logic [15:0] T_CF [NV] = '{
        16'h4000, 16'h4000, 16'h4000, 16'h4000, 16'h7FFF,
        16'h7FFF, 16'h8000, 16'h8000, 16'h0000 };
    localparam logic signed [11:0] T_EX [NV] = '{
        12'sd500, -12'sd500, 12'sd2, -12'sd1, 12'sd2047,
        -12'sd2048, 12'sd2047, -12'sd2047, 12'sd0 };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic sample(input logic [11:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic ref_pulse(input logic [11:0] c0, input logic [11:0] c1);
        @(negedge clk);
        ref_valid = 1'b1; ref_data = {c1, c0};
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; ref_valid = 1'b0; ref_data = '0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 out_valid", {15'd0, out_valid}, 16'd0);
        check("R1 irq", {14'd0, irq_in, irq_out}, 16'd0);
        check("R1 rdata", reg_rdata, 16'd0);
        rd(3'd0);
        check("R1 ctrl", reg_rdata, 16'd0);

        // R2 / R3 vector table, register coefficient mode
        wr(3'd0, 16'h0001);
        for (int i = 0; i < NV; i++) begin
            wr(3'd1, T_CF[i]);
            sample(T_IN[i]);
            check($sformatf("R2 R3 vec%0d valid", i), {15'd0, out_valid}, 16'd1);
            check($sformatf("R2 R3 vec%0d data", i), {4'd0, out_data}, {4'd0, T_EX[i]});
        end
        rd(3'd0);
        check("R3 sticky set", {15'd0, reg_rdata[8]}, 16'd1);
        wr(3'd0, 16'h8001);
        rd(3'd0);
        check("R3 sticky cleared", {15'd0, reg_rdata[8]}, 16'd0);

        // R4 sample-by-sample coefficient rewrite
        wr(3'd1, 16'h4000); sample(12'd400);
        check("R4 step a", {4'd0, out_data}, 16'd200);
        wr(3'd1, 16'h2000); sample(12'd400);
        check("R4 step b", {4'd0, out_data}, 16'd100);
        wr(3'd1, 16'hC000); sample(12'd400);
        check("R4 step c", {4'd0, out_data}, {4'd0, 12'hF38});

        // R9 input tap and its flag
        check("R9 irq_in set", {15'd0, irq_in}, 16'd1);
        rd(3'd6);
        check("R9 itap", reg_rdata, 16'h0190);
        check("R9 irq_in clear", {15'd0, irq_in}, 16'd0);

        // R10 output tap, clear, then clear colliding with new output
        check("R10 irq_out set", {15'd0, irq_out}, 16'd1);
        rd(3'd7);
        check("R10 otap", reg_rdata, 16'hFF38);
        check("R10 irq_out clear", {15'd0, irq_out}, 16'd0);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'd7; in_valid = 1'b1; in_data = 12'd400;
        @(negedge clk);
        reg_rd = 1'b0; in_valid = 1'b0;
        check("R10 set wins", {15'd0, irq_out}, 16'd1);

        // R7 bypass
        wr(3'd0, 16'h0000);
        sample(12'd777);
        check("R7 bypass valid", {15'd0, out_valid}, 16'd1);
        check("R7 bypass data", {4'd0, out_data}, 16'd777);

        // R8 software source
        wr(3'd0, 16'h0004);
        sample(12'd555);
        check("R8 input ignored valid", {15'd0, out_valid}, 16'd0);
        check("R8 input ignored data", {4'd0, out_data}, 16'd777);
        wr(3'd2, 16'h0123);
        check("R8 src valid", {15'd0, out_valid}, 16'd1);
        check("R8 src data", {4'd0, out_data}, 16'h0123);

        // R5 oscillator coefficient, quarter-turn steps
        wr(3'd0, 16'h0003);
        wr(3'd5, 16'h0000);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0040);
        sample(12'd1000); check("R5 q0", {4'd0, out_data}, 16'd0);
        sample(12'd1000); check("R5 q1", {4'd0, out_data}, 16'd1000);
        sample(12'd1000); check("R5 q2", {4'd0, out_data}, 16'd0);
        sample(12'd1000); check("R5 q3", {4'd0, out_data}, {4'd0, 12'hC18});
        sample(12'd1000); check("R5 wrap", {4'd0, out_data}, 16'd0);
        wr(3'd4, 16'h0040);
        sample(12'd1000); check("R5 reload phase", {4'd0, out_data}, 16'd0);

        // R6 phase detector follows only the selected channel
        wr(3'd4, 16'h0000);
        wr(3'd5, 16'h003C);
        ref_pulse(12'd1025, 12'd0);
        sample(12'd1000); check("R6 unselected a", {4'd0, out_data}, 16'd0);
        sample(12'd1000); check("R6 unselected b", {4'd0, out_data}, 16'd0);
        ref_pulse(12'd0, 12'd1025);
        sample(12'd1000); check("R6 selected a", {4'd0, out_data}, 16'd0);
        sample(12'd1000); check("R6 selected b", {4'd0, out_data}, 16'd1000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule